// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register Block

This block holds the control and status registers of a two-channel disk controller and is reached over a simple synchronous register bus. The bus has an address, write data, an access size, read and write strobes, and registered read data. For each channel it keeps several registers: a DMA command byte, a DMA status byte that mixes field types, a six-bit scratch byte, a twelve-bit link control word, an interrupt enable field, and an interrupt flag that appears inside a read-only configuration word. The two channel interrupt flags are merged into one level interrupt.

Several registers can also be written through a second offset. Two summary words gather command, status and interrupt flags into a single read. A write of the command byte is passed on to an external DMA engine as a one-clock strobe that carries the written byte. A link control write with bit 0 set sends a one-clock reset pulse to that channel's device bus. The task-file registers, the DMA engine and configuration space are outside this block, and their offsets read as zero here.

Top module: `duo_disk_csr`

## Requirements
- R1: After reset, the command, status, scratch, link control and enable registers read zero. Both configuration words read 0x6515_0000, and irq_out, bus_reset and dma_cmd_stb are low.
- R2: A write to offset 0x00 or 0x10 stores wdata[7:0] as the channel 0 command byte, and a write to 0x08 or 0x18 does the same for channel 1. Reads at 0x00 and 0x08 return that byte. In the cycle after the write, dma_cmd_stb[ch] is high for one clock and dma_cmd_byte[8*ch+7:8*ch] holds the written byte.
- R3: The status byte is written at 0x02 or 0x12 (channel 0) and at 0x0A or 0x1A (channel 1), and read at 0x02 and 0x0A. Bits 6:5 take wdata[6:5]. Bits 2:1 are cleared where wdata has a 1 and kept where it has a 0. Input dma_st_set[2*ch] sets bit 1 and dma_st_set[2*ch+1] sets bit 2, and a set wins over a clear in the same cycle. Bit 0 shows dma_busy[ch] as it is now. Bits 7, 4 and 3 read zero.
- R4: The scratch byte is written at 0x01 or 0x11 (channel 0) and at 0x09 or 0x19 (channel 1), and read at 0x01 and 0x09. Only wdata[5:0] is kept.
- R5: A word write to 0x100 (channel 0) or 0x180 (channel 1) stores wdata[11:0] as link control, which reads back zero-extended. If wdata[0] is 1, bus_reset[ch] is high for exactly the one clock after the write.
- R6: A word write to 0x148 (channel 0) or 0x1C8 (channel 1) stores wdata[31:16] ANDed with 0x3EED. A read at that offset returns the field in bits 31:16 and zero below.
- R7: The configuration word at 0xA0 (channel 0) or 0xE0 (channel 1) reads 0x6515 in bits 31:16 and the channel interrupt flag in bit 11, with all other bits zero. The flag takes irq_in[ch] at each clock edge.
- R8: irq_out is the OR of the two channel interrupt flags.
- R9: A read at 0x10 returns the following fields, ORed together:
  - the channel 0 command byte in bits 7:0;
  - the channel 0 flag in bit 4;
  - the channel 1 flag in bit 6;
  - channel 1 status bit 2 in bit 14;
  - the channel 0 status in bits 23:16;
  - the channel 1 status in bits 31:24.

  A read at 0x18 returns the channel 1 command byte ORed with the channel 1 flag in bit 4, and the channel 1 status in bits 23:16.
- R10: A read at 0x104 (channel 0) or 0x184 (channel 1) returns 0x113 when dev_present[ch] is high and 0 otherwise.
- R11: Reads return zero at 0x03, 0x0B, the write-only offsets 0x11 and 0x19, and every unmapped offset. Writes to unmapped or read-only offsets change nothing. bus_rdata is loaded on the clock edge that samples bus_rd and holds its value until the next read.
- R12: The link control and enable registers accept only size 2'd2, a 32-bit word. Byte (2'd0) and half-word (2'd1) writes to them are ignored and cause no bus_reset pulse. The byte-wide registers take wdata[7:0] at any size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq_in | input | 2 | Per-channel device interrupt level |
| dev_present | input | 2 | Per-channel device present |
| dma_busy | input | 2 | Per-channel DMA active, shown in status bit 0 |
| dma_st_set | input | 4 | Per-channel set pulses for status bits 1 and 2 |
| irq_out | output | 1 | Merged interrupt level |
| bus_reset | output | 2 | One-clock device bus reset pulses |
| dma_cmd_stb | output | 2 | One-clock command write strobes |
| dma_cmd_byte | output | 16 | Last written command byte per channel |

## Verification
The bench builds the block with its defaults: a 9-bit address, a 32-bit data bus and a combinational interrupt output. With a 9-bit address every offset up to 0x1FF can be reached, so the second link region and the unmapped space above it are exercised. A registered interrupt output would add one clock to R8 and is left unexercised. Directed scenarios drive the mixed status fields through a set and clear in the same cycle, and check the summary words with both interrupt flags in different states.

// File: rtl/duo_csr_pkg.sv
`timescale 1ns/1ps
package duo_csr_pkg;
   localparam int unsigned NCH    = 2;
   localparam int unsigned CMD_W  = 8;
   localparam int unsigned ST_W   = 8;
   localparam int unsigned SWD_W  = 6;
   localparam int unsigned LCTL_W = 12;
   localparam int unsigned IEN_W  = 16;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic [CMD_W-1:0]  cmd;
      logic [ST_W-1:0]   st;
      logic [SWD_W-1:0]  swd;
      logic [LCTL_W-1:0] lctl;
      logic [IEN_W-1:0]  ien;
      logic              flag;
   } chan_view_t;

   // offset map, derived from the channel index
   function automatic int unsigned off_cmd(int unsigned ch);
      return ch * 8;
   endfunction
   function automatic int unsigned off_alias(int unsigned ch);
      return 16 + ch * 8;
   endfunction
   function automatic int unsigned off_conf(int unsigned ch);
      return 160 + ch * 64;
   endfunction
   function automatic int unsigned off_link(int unsigned ch);
      return 256 + ch * 128;
   endfunction
   function automatic int unsigned off_ien(int unsigned ch);
      return 256 + ch * 128 + 72;
   endfunction
endpackage

// File: rtl/duo_csr_chan.sv
`timescale 1ns/1ps
module duo_csr_chan
   import duo_csr_pkg::*;
#(
   parameter int unsigned CH       = 0,
   parameter int unsigned ADDR_W   = 9,
   parameter int unsigned DATA_W   = 32,
   parameter logic [15:0] IEN_MASK = 16'h3EED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        size,
   input  logic              busy,
   input  logic [1:0]        st_set,
   input  logic              irq_lvl,
   output chan_view_t        view,
   output logic              bus_rst,
   output logic              cmd_stb,
   output logic [CMD_W-1:0]  cmd_byte
);
   localparam int unsigned A_CMD  = off_cmd(CH);
   localparam int unsigned A_ALT  = off_alias(CH);
   localparam int unsigned A_LINK = off_link(CH);
   localparam int unsigned A_IEN  = off_ien(CH);

   logic              hit_cmd, hit_swd, hit_st, hit_lctl, hit_ien, word_ok;
   logic [CMD_W-1:0]  cmd_q;
   logic [SWD_W-1:0]  swd_q;
   logic [1:0]        st_rw_q;
   logic [1:0]        st_w1c_q;
   logic [1:0]        clr_mask;
   logic [LCTL_W-1:0] lctl_q;
   logic [IEN_W-1:0]  ien_q;
   logic              flag_q;
   logic              unused_wdata;

   assign unused_wdata = ^wdata[15:LCTL_W] ^ (^wdata[4:3]) ^ wdata[7];

   assign word_ok  = (size == SZ_WORD);
   assign hit_cmd  = wr && (addr == ADDR_W'(A_CMD) || addr == ADDR_W'(A_ALT));
   assign hit_swd  = wr && (addr == ADDR_W'(A_CMD + 1) || addr == ADDR_W'(A_ALT + 1));
   assign hit_st   = wr && (addr == ADDR_W'(A_CMD + 2) || addr == ADDR_W'(A_ALT + 2));
   assign hit_lctl = wr && word_ok && (addr == ADDR_W'(A_LINK));
   assign hit_ien  = wr && word_ok && (addr == ADDR_W'(A_IEN));
   assign clr_mask = hit_st ? wdata[2:1] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         swd_q    <= '0;
         st_rw_q  <= '0;
         st_w1c_q <= '0;
         lctl_q   <= '0;
         ien_q    <= '0;
         flag_q   <= 1'b0;
         bus_rst  <= 1'b0;
         cmd_stb  <= 1'b0;
         cmd_byte <= '0;
      end else begin
         flag_q   <= irq_lvl;
         bus_rst  <= hit_lctl && wdata[0];
         cmd_stb  <= hit_cmd;
         st_w1c_q <= (st_w1c_q & ~clr_mask) | st_set;
         if (hit_cmd) begin
            cmd_q    <= wdata[CMD_W-1:0];
            cmd_byte <= wdata[CMD_W-1:0];
         end
         if (hit_swd)  swd_q   <= wdata[SWD_W-1:0];
         if (hit_st)   st_rw_q <= wdata[6:5];
         if (hit_lctl) lctl_q  <= wdata[LCTL_W-1:0];
         if (hit_ien)  ien_q   <= wdata[31:16] & IEN_MASK;
      end
   end

   always_comb begin
      view      = '0;
      view.cmd  = cmd_q;
      view.st   = {1'b0, st_rw_q, 2'b00, st_w1c_q, busy};
      view.swd  = swd_q;
      view.lctl = lctl_q;
      view.ien  = ien_q;
      view.flag = flag_q;
   end
endmodule

// File: rtl/duo_csr_rdmux.sv
`timescale 1ns/1ps
module duo_csr_rdmux
   import duo_csr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned DATA_W  = 32,
   parameter logic [15:0] CONF_ID = 16'h6515,
   parameter logic [11:0] LINK_UP = 12'h113
) (
   input  logic [ADDR_W-1:0]       addr,
   input  chan_view_t [NCH-1:0]    views,
   input  logic [NCH-1:0]          present,
   output logic [DATA_W-1:0]       rsel
);
   always_comb begin
      rsel = '0;
      for (int unsigned ch = 0; ch < NCH; ch++) begin
         if (addr == ADDR_W'(off_cmd(ch)))
            rsel = DATA_W'(views[ch].cmd);
         if (addr == ADDR_W'(off_cmd(ch) + 1))
            rsel = DATA_W'(views[ch].swd);
         if (addr == ADDR_W'(off_cmd(ch) + 2))
            rsel = DATA_W'(views[ch].st);
         if (addr == ADDR_W'(off_conf(ch)))
            rsel = DATA_W'({CONF_ID, 4'h0, views[ch].flag, 11'h000});
         if (addr == ADDR_W'(off_link(ch)))
            rsel = DATA_W'(views[ch].lctl);
         if (addr == ADDR_W'(off_link(ch) + 4))
            rsel = present[ch] ? DATA_W'(LINK_UP) : '0;
         if (addr == ADDR_W'(off_ien(ch)))
            rsel = DATA_W'({views[ch].ien, 16'h0000});
      end
      if (addr == ADDR_W'(off_alias(0))) begin
         rsel = DATA_W'({views[1].st, views[0].st,
                         1'b0, views[1].st[2], 6'b0, views[0].cmd})
              | DATA_W'({views[1].flag, 1'b0, views[0].flag, 4'b0});
      end
      if (addr == ADDR_W'(off_alias(1))) begin
         rsel = DATA_W'({views[1].st, 8'h00, views[1].cmd})
              | DATA_W'({views[1].flag, 4'b0});
      end
   end
endmodule

// File: rtl/duo_csr_irq.sv
`timescale 1ns/1ps
module duo_csr_irq #(
   parameter int unsigned N       = 2,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   output logic         irq
);
   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |flags;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = |flags;
      end
   endgenerate
endmodule

// File: rtl/duo_disk_csr.sv
`timescale 1ns/1ps
module duo_disk_csr
   import duo_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 9,
   parameter int unsigned DATA_W   = 32,
   parameter logic [15:0] IEN_MASK = 16'h3EED,
   parameter logic [15:0] CONF_ID  = 16'h6515,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [1:0]        bus_size,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [1:0]        irq_in,
   input  logic [1:0]        dev_present,
   input  logic [1:0]        dma_busy,
   input  logic [3:0]        dma_st_set,
   output logic              irq_out,
   output logic [1:0]        bus_reset,
   output logic [1:0]        dma_cmd_stb,
   output logic [15:0]       dma_cmd_byte
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("duo_disk_csr: summary layout needs DATA_W of 32");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("duo_disk_csr: offset map needs ADDR_W of at least 9");
      end
   endgenerate

   chan_view_t [NCH-1:0] views;
   logic [NCH-1:0]       flags;
   logic [DATA_W-1:0]    rsel;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      duo_csr_chan #(
         .CH(ch), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IEN_MASK(IEN_MASK)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (bus_wr),
         .addr    (bus_addr),
         .wdata   (bus_wdata),
         .size    (bus_size),
         .busy    (dma_busy[ch]),
         .st_set  (dma_st_set[2*ch+1:2*ch]),
         .irq_lvl (irq_in[ch]),
         .view    (views[ch]),
         .bus_rst (bus_reset[ch]),
         .cmd_stb (dma_cmd_stb[ch]),
         .cmd_byte(dma_cmd_byte[8*ch+7:8*ch])
      );
      assign flags[ch] = views[ch].flag;
   end

   duo_csr_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONF_ID(CONF_ID)
   ) u_rdmux (
      .addr   (bus_addr),
      .views  (views),
      .present(dev_present),
      .rsel   (rsel)
   );

   duo_csr_irq #(.N(NCH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .flags(flags),
      .irq  (irq_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rsel;
   end
endmodule

// File: rtl/duo_csr_chk.sv
`timescale 1ns/1ps
module duo_csr_chk #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [1:0]        bus_size,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        irq_in,
   input logic              irq_out,
   input logic [1:0]        bus_reset,
   input logic [1:0]        dma_cmd_stb,
   input logic [15:0]       dma_cmd_byte
);
   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   // R5
   link_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset[0] |=> !bus_reset[0]);

   // R5
   link_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && bus_reset[0]) |-> ($past(bus_wr) && $past(bus_addr) == ADDR_W'(256)
                                     && $past(bus_size) == 2'd2 && $past(bus_wdata[0])));

   // R2
   cmd_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && dma_cmd_stb[0]) |-> ($past(bus_wr) && dma_cmd_byte[7:0] == $past(bus_wdata[7:0])));

   // R11
   hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(bus_rd) && $past(bus_addr) == ADDR_W'(3)) |-> bus_rdata == '0);

   // R7
   conf_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(bus_rd) && $past(bus_addr) == ADDR_W'(160)) |-> bus_rdata[31:16] == 16'h6515);

   generate
      if (!IRQ_REG) begin : g_irq_chk
         // R8
         irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            started |-> irq_out == |$past(irq_in));
      end
   endgenerate
endmodule

bind duo_disk_csr duo_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_size    (bus_size),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_rdata   (bus_rdata),
   .irq_in      (irq_in),
   .irq_out     (irq_out),
   .bus_reset   (bus_reset),
   .dma_cmd_stb (dma_cmd_stb),
   .dma_cmd_byte(dma_cmd_byte)
);

// File: tb/duo_disk_csr_bench.sv
`timescale 1ns/1ps
module duo_disk_csr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [1:0]  bus_size = 2'd0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq_in = '0;
   logic [1:0]  dev_present = '0;
   logic [1:0]  dma_busy = '0;
   logic [3:0]  dma_st_set = '0;
   logic        irq_out;
   logic [1:0]  bus_reset;
   logic [1:0]  dma_cmd_stb;
   logic [15:0] dma_cmd_byte;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [1:0]  snap_rst, snap_stb;
   logic [15:0] snap_byte;
   logic [31:0] rd_val;

   always #2.5 clk = ~clk;

   duo_disk_csr u_duo_disk_csr (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .dev_present(dev_present), .dma_busy(dma_busy),
      .dma_st_set(dma_st_set), .irq_out(irq_out), .bus_reset(bus_reset),
      .dma_cmd_stb(dma_cmd_stb), .dma_cmd_byte(dma_cmd_byte)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [8:0] a, logic [31:0] d, logic [1:0] sz);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; dma_st_set = '0;
      snap_rst = bus_reset; snap_stb = dma_cmd_stb; snap_byte = dma_cmd_byte;
   endtask

   task automatic rd(logic [8:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      rd_val = bus_rdata;
   endtask

   task automatic rd_chk(string req, logic [8:0] a, logic [31:0] exp);
      rd(a);
      chk(req, rd_val, exp);
   endtask

   task automatic t_reset;
      chk("R1 irq_out", {31'b0, irq_out}, 0);
      chk("R1 pulses", {28'b0, bus_reset, dma_cmd_stb}, 0);
      rd_chk("R1 cmd0", 9'h000, 0);
      rd_chk("R1 st1", 9'h00A, 0);
      rd_chk("R1 swd0", 9'h001, 0);
      rd_chk("R1 link1", 9'h180, 0);
      rd_chk("R1 ien0", 9'h148, 0);
      rd_chk("R1 conf0", 9'h0A0, 32'h6515_0000);
      rd_chk("R1 conf1", 9'h0E0, 32'h6515_0000);
   endtask

   task automatic t_cmd;
      wr(9'h000, 32'hFFFF_FFA5, 2'd0);
      chk("R2 stb ch0", {30'b0, snap_stb}, 32'h1);
      chk("R2 byte ch0", {24'b0, snap_byte[7:0]}, 32'hA5);
      @(negedge clk);
      chk("R2 stb one clock", {30'b0, dma_cmd_stb}, 0);
      rd_chk("R2 cmd0", 9'h000, 32'hA5);
      wr(9'h018, 32'h3C, 2'd0);
      chk("R2 stb ch1 alias", {30'b0, snap_stb}, 32'h2);
      chk("R2 byte ch1", {24'b0, snap_byte[15:8]}, 32'h3C);
      rd_chk("R2 cmd1", 9'h008, 32'h3C);
      wr(9'h010, 32'h5A, 2'd0);
      rd_chk("R2 cmd0 alias", 9'h000, 32'h5A);
   endtask

   task automatic t_status;
      wr(9'h002, 32'hFF, 2'd0);
      rd_chk("R3 rw bits only", 9'h002, 32'h60);
      @(negedge clk); dma_st_set = 4'b0011;
      @(negedge clk); dma_st_set = '0;
      rd_chk("R3 set pulses", 9'h002, 32'h66);
      wr(9'h012, 32'h02, 2'd0);
      rd_chk("R3 w1c bit1 alias", 9'h002, 32'h04);
      dma_busy = 2'b01;
      rd_chk("R3 busy bit0", 9'h002, 32'h05);
      dma_st_set = 4'b0010;
      wr(9'h002, 32'h04, 2'd0);
      rd_chk("R3 set wins", 9'h002, 32'h05);
      dma_busy = 2'b00;
      wr(9'h002, 32'h06, 2'd0);
      rd_chk("R3 cleared", 9'h002, 32'h00);
      wr(9'h01A, 32'h40, 2'd0);
      rd_chk("R3 ch1 alias", 9'h00A, 32'h40);
      wr(9'h00A, 32'h06, 2'd0);
      rd_chk("R3 ch1 rw zero", 9'h00A, 32'h00);
   endtask

   task automatic t_swd;
      wr(9'h001, 32'hFF, 2'd0);
      rd_chk("R4 swd0 mask", 9'h001, 32'h3F);
      wr(9'h019, 32'hAA, 2'd0);
      rd_chk("R4 swd1 alias", 9'h009, 32'h2A);
   endtask

   task automatic t_link;
      wr(9'h100, 32'hFFFF_F001, 2'd2);
      chk("R5 pulse ch0", {30'b0, snap_rst}, 32'h1);
      @(negedge clk);
      chk("R5 pulse ends", {30'b0, bus_reset}, 0);
      rd_chk("R5 link0", 9'h100, 32'h001);
      wr(9'h180, 32'h0000_0ABC, 2'd2);
      chk("R5 no pulse", {30'b0, snap_rst}, 0);
      rd_chk("R5 link1", 9'h180, 32'hABC);
      wr(9'h180, 32'h0000_0FFF, 2'd2);
      chk("R5 pulse ch1", {30'b0, snap_rst}, 32'h2);
      wr(9'h100, 32'h0000_00FF, 2'd0);
      chk("R12 byte no pulse", {30'b0, snap_rst}, 0);
      rd_chk("R12 link byte ignored", 9'h100, 32'h001);
   endtask

   task automatic t_ien;
      wr(9'h148, 32'hFFFF_FFFF, 2'd2);
      rd_chk("R6 ien0 mask", 9'h148, 32'h3EED_0000);
      wr(9'h1C8, 32'h1234_5678, 2'd2);
      rd_chk("R6 ien1", 9'h1C8, 32'h1224_0000);
      wr(9'h148, 32'h0000_0000, 2'd1);
      rd_chk("R12 ien half ignored", 9'h148, 32'h3EED_0000);
   endtask

   task automatic t_irq;
      @(negedge clk); irq_in = 2'b01;
      @(negedge clk);
      chk("R8 irq ch0", {31'b0, irq_out}, 1);
      rd_chk("R7 conf0 flag", 9'h0A0, 32'h6515_0800);
      rd_chk("R7 conf1 clear", 9'h0E0, 32'h6515_0000);
      @(negedge clk); irq_in = 2'b10;
      @(negedge clk);
      chk("R8 irq ch1", {31'b0, irq_out}, 1);
      rd_chk("R7 conf1 flag", 9'h0E0, 32'h6515_0800);
      @(negedge clk); irq_in = 2'b00;
      @(negedge clk);
      chk("R8 irq low", {31'b0, irq_out}, 0);
   endtask

   task automatic t_summary;
      wr(9'h000, 32'h81, 2'd0);
      wr(9'h008, 32'h22, 2'd0);
      wr(9'h002, 32'h20, 2'd0);
      dma_st_set = 4'b1000;
      irq_in = 2'b10;
      @(negedge clk); dma_st_set = '0;
      @(negedge clk);
      rd_chk("R9 summary 0x10", 9'h010, 32'h0420_40C1);
      rd_chk("R9 summary 0x18", 9'h018, 32'h0004_0032);
      irq_in = 2'b01;
      @(negedge clk);
      rd_chk("R9 summary 0x10 ch0 flag", 9'h010, 32'h0420_4091);
      rd_chk("R9 summary 0x18 no flag", 9'h018, 32'h0004_0022);
      irq_in = 2'b00;
      wr(9'h00A, 32'h06, 2'd0);
   endtask

   task automatic t_present;
      dev_present = 2'b01;
      rd_chk("R10 ch0 up", 9'h104, 32'h113);
      rd_chk("R10 ch1 down", 9'h184, 32'h0);
      dev_present = 2'b10;
      rd_chk("R10 ch0 down", 9'h104, 32'h0);
      rd_chk("R10 ch1 up", 9'h184, 32'h113);
      dev_present = 2'b00;
   endtask

   task automatic t_holes;
      wr(9'h040, 32'hFFFF_FFFF, 2'd2);
      wr(9'h0A0, 32'hFFFF_FFFF, 2'd2);
      wr(9'h104, 32'hFFFF_FFFF, 2'd2);
      rd_chk("R11 0x03", 9'h003, 0);
      rd_chk("R11 0x0B", 9'h00B, 0);
      rd_chk("R11 0x11", 9'h011, 0);
      rd_chk("R11 0x19", 9'h019, 0);
      rd_chk("R11 unmapped", 9'h040, 0);
      rd_chk("R11 conf read-only", 9'h0A0, 32'h6515_0000);
      rd_chk("R11 link status ro", 9'h104, 32'h0);
      rd_chk("R11 cmd0 intact", 9'h000, 32'h81);
      rd_chk("R11 hold pre", 9'h001, 32'h3F);
      bus_addr = 9'h000;
      @(negedge clk); @(negedge clk);
      chk("R11 rdata held", bus_rdata, 32'h3F);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_cmd;
      t_status;
      t_swd;
      t_link;
      t_ien;
      t_irq;
      t_summary;
      t_present;
      t_holes;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule